// File: doc/BRIEF.md
# Ethernet Pause Frame Detector

This block watches a received Ethernet frame one byte at a time, starting at the first destination address byte after the preamble and start delimiter. It decides whether the frame is a MAC control PAUSE request. A frame qualifies when four things hold together: its destination is the reserved flow-control multicast address or the station's own address, its type and opcode fields identify a PAUSE, it carries a complete 16-bit duration field, and the receive status delivered with its last byte marks it good.

A qualifying frame produces a one-cycle detection pulse. The pause quanta taken from the frame are presented with the pulse and held until the next detection. Detection works only while full-duplex operation and receive flow control are both enabled. CRC checking, address hashing and the pause timer are handled elsewhere. Frame validity arrives as an input flag.

Top module: `pause_detector`

## Requirements
- R1: A detection needs `full_duplex_i` and `flow_ctrl_en_i` both high in the cycle of the end-of-frame byte. If either is low, no pulse is produced.
- R2: Destination address 01-80-C2-00-00-01 is accepted. Byte 01 is received first, and address bytes are compared in arrival order.
- R3: A destination address equal to `station_addr_i` is accepted, with bits 47:40 matching the first received byte. Any other destination address prevents detection.
- R4: The six source address bytes (frame bytes 6 to 11) are not checked and may hold any value.
- R5: Frame bytes 12 and 13 must be 0x88 then 0x08 (type 0x8808). Otherwise there is no detection.
- R6: Frame bytes 14 and 15 must be 0x00 then 0x01 (opcode 0x0001). Otherwise there is no detection.
- R7: Frame bytes 16 and 17 form the pause quanta, most significant byte first. Any value from 0x0000 to 0xFFFF is valid. `pause_quanta_o` takes the new value with the pulse and holds it otherwise.
- R8: A detection needs `rx_good_i` high with the end-of-frame byte.
- R9: A frame whose end-of-frame byte comes before byte 17 produces no pulse. Bytes after byte 17 (padding) do not affect the result.
- R10: `pause_det_o` is high for exactly one cycle: the cycle after the accepted end-of-frame byte. It is low at all other times.
- R11: A byte with `rx_sof_i` high starts a new frame at byte 0, even in the middle of a frame. Cycles with `rx_valid_i` low are not counted. Bytes arriving between an end-of-frame and the next start-of-frame are ignored.
- R12: While reset is held, and after it is released, `pause_det_o` and `pause_quanta_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_valid_i | input | 1 | Byte strobe for rx_data_i |
| rx_data_i | input | 8 | Received frame byte |
| rx_sof_i | input | 1 | Marks the first byte of the frame (destination address byte 0) |
| rx_eof_i | input | 1 | Marks the last byte of the frame |
| rx_good_i | input | 1 | Frame status, sampled with the end-of-frame byte |
| station_addr_i | input | 48 | Station address; bits 47:40 are received first |
| full_duplex_i | input | 1 | Full-duplex operation enabled |
| flow_ctrl_en_i | input | 1 | Receive flow control enabled |
| pause_det_o | output | 1 | One-cycle pulse marking a detected PAUSE frame |
| pause_quanta_o | output | 16 | Pause quanta from the last detected frame |

## Verification
Both results are due exactly one clock edge after the end-of-frame byte is taken. The pulse and the quanta come from one register stage fed by the decision made on that last byte. The bench drives every byte on a falling edge and samples the outputs on the next falling edge after the end-of-frame edge, so both results are checked in their own cycle. The pulse is also sampled during every byte of each frame and again one cycle after it was seen high, which confirms it rises only in the due cycle and falls right after. Frames that must not be detected are followed by a check that the quanta output still holds the value from the previous detection.

// File: rtl/pause_det_pkg.sv
package pause_det_pkg;
  localparam int BYTE_W     = 8;
  localparam int ADDR_W     = 48;
  localparam int QUANTA_W   = 16;
  localparam int ADDR_BYTES = ADDR_W / BYTE_W;
  localparam int CTL_BYTES  = 4;                       // type + opcode
  localparam int CTL_OFS    = 2 * ADDR_BYTES;          // 12
  localparam int QNT_OFS    = CTL_OFS + CTL_BYTES;     // 16
  localparam int HDR_LEN    = QNT_OFS + QUANTA_W / BYTE_W; // 18
  localparam int POS_W      = $clog2(HDR_LEN + 1);

  localparam logic [ADDR_W-1:0]           FC_MCAST_ADDR = 48'h0180_C200_0001;
  localparam logic [CTL_BYTES*BYTE_W-1:0] PAUSE_CTL     = 32'h8808_0001;
endpackage

// File: rtl/pd_byte_tracker.sv
module pd_byte_tracker
  import pause_det_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             vld_i,
  input  logic             sof_i,
  input  logic             eof_i,
  output logic             take_o,
  output logic [POS_W-1:0] pos_o,
  output logic             hdr_done_o
);
  logic             in_frame_q;
  logic [POS_W-1:0] cnt_q;

  assign take_o     = vld_i & (sof_i | in_frame_q);
  assign pos_o      = sof_i ? '0 : cnt_q;
  // header complete once the last quanta byte is the current byte or behind us
  assign hdr_done_o = take_o & (pos_o >= POS_W'(HDR_LEN - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_frame_q <= 1'b0;
      cnt_q      <= '0;
    end else if (take_o) begin
      in_frame_q <= ~eof_i;
      cnt_q      <= (pos_o == POS_W'(HDR_LEN)) ? pos_o : pos_o + 1'b1;
    end
  end
endmodule

// File: rtl/pd_field_check.sv
module pd_field_check
  import pause_det_pkg::*;
#(
  parameter bit ACCEPT_STATION = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              take_i,
  input  logic              sof_i,
  input  logic [POS_W-1:0]  pos_i,
  input  logic [BYTE_W-1:0] data_i,
  input  logic [ADDR_W-1:0] station_addr_i,
  output logic              hdr_ok_o
);
  logic mc_q, st_q, ctl_q;
  logic mc_n, st_n, ctl_n;
  logic in_da, in_ctl;
  logic [BYTE_W-1:0] mc_byte, st_byte, ctl_byte;
  int unsigned da_idx, ctl_idx;

  assign in_da  = pos_i < POS_W'(ADDR_BYTES);
  assign in_ctl = (pos_i >= POS_W'(CTL_OFS)) && (pos_i < POS_W'(QNT_OFS));

  always_comb begin
    da_idx   = ADDR_BYTES - 1 - int'(pos_i);
    ctl_idx  = CTL_BYTES - 1 - (int'(pos_i) - CTL_OFS);
    mc_byte  = '0;
    st_byte  = '0;
    ctl_byte = '0;
    if (in_da) begin
      mc_byte = FC_MCAST_ADDR[da_idx*BYTE_W +: BYTE_W];
      st_byte = station_addr_i[da_idx*BYTE_W +: BYTE_W];
    end
    if (in_ctl) ctl_byte = PAUSE_CTL[ctl_idx*BYTE_W +: BYTE_W];
  end

  always_comb begin
    mc_n  = sof_i ? 1'b1 : mc_q;
    ctl_n = sof_i ? 1'b1 : ctl_q;
    if (in_da)  mc_n  = mc_n & (data_i == mc_byte);
    if (in_ctl) ctl_n = ctl_n & (data_i == ctl_byte);
  end

  generate
    if (ACCEPT_STATION) begin : g_station
      always_comb begin
        st_n = sof_i ? 1'b1 : st_q;
        if (in_da) st_n = st_n & (data_i == st_byte);
      end
    end else begin : g_no_station
      assign st_n = 1'b0;
    end
  endgenerate

  assign hdr_ok_o = (mc_n | st_n) & ctl_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mc_q  <= 1'b0;
      st_q  <= 1'b0;
      ctl_q <= 1'b0;
    end else if (take_i) begin
      mc_q  <= mc_n;
      st_q  <= st_n;
      ctl_q <= ctl_n;
    end
  end
endmodule

// File: rtl/pd_quanta_capture.sv
module pd_quanta_capture
  import pause_det_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                take_i,
  input  logic [POS_W-1:0]    pos_i,
  input  logic [BYTE_W-1:0]   data_i,
  output logic [QUANTA_W-1:0] quanta_o
);
  logic [QUANTA_W-1:0] sr_q;
  logic                in_qnt;

  assign in_qnt   = take_i && (pos_i >= POS_W'(QNT_OFS)) && (pos_i < POS_W'(HDR_LEN));
  // include the byte in flight so the value is ready on the final quanta byte
  assign quanta_o = in_qnt ? {sr_q[QUANTA_W-BYTE_W-1:0], data_i} : sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sr_q <= '0;
    else if (in_qnt) sr_q <= quanta_o;
  end
endmodule

// File: rtl/pause_detector.sv
module pause_detector
  import pause_det_pkg::*;
#(
  parameter bit ACCEPT_STATION = 1'b1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                rx_valid_i,
  input  logic [BYTE_W-1:0]   rx_data_i,
  input  logic                rx_sof_i,
  input  logic                rx_eof_i,
  input  logic                rx_good_i,
  input  logic [ADDR_W-1:0]   station_addr_i,
  input  logic                full_duplex_i,
  input  logic                flow_ctrl_en_i,
  output logic                pause_det_o,
  output logic [QUANTA_W-1:0] pause_quanta_o
);
  logic             take, hdr_done, hdr_ok, det_n;
  logic [POS_W-1:0] pos;
  logic [QUANTA_W-1:0] quanta_n;

  pd_byte_tracker u_trk (
    .clk_i, .rst_ni,
    .vld_i      (rx_valid_i),
    .sof_i      (rx_sof_i),
    .eof_i      (rx_eof_i),
    .take_o     (take),
    .pos_o      (pos),
    .hdr_done_o (hdr_done)
  );

  pd_field_check #(.ACCEPT_STATION(ACCEPT_STATION)) u_chk_fld (
    .clk_i, .rst_ni,
    .take_i         (take),
    .sof_i          (rx_sof_i),
    .pos_i          (pos),
    .data_i         (rx_data_i),
    .station_addr_i (station_addr_i),
    .hdr_ok_o       (hdr_ok)
  );

  pd_quanta_capture u_qnt (
    .clk_i, .rst_ni,
    .take_i   (take),
    .pos_i    (pos),
    .data_i   (rx_data_i),
    .quanta_o (quanta_n)
  );

  assign det_n = take & rx_eof_i & rx_good_i & full_duplex_i & flow_ctrl_en_i
               & hdr_done & hdr_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pause_det_o    <= 1'b0;
      pause_quanta_o <= '0;
    end else begin
      pause_det_o <= det_n;
      if (det_n) pause_quanta_o <= quanta_n;
    end
  end
endmodule

// File: rtl/pause_detector_chk.sv
module pause_detector_chk
  import pause_det_pkg::*;
(
  input logic                clk_i,
  input logic                rst_ni,
  input logic                rx_valid_i,
  input logic                rx_eof_i,
  input logic                rx_good_i,
  input logic                full_duplex_i,
  input logic                flow_ctrl_en_i,
  input logic                pause_det_o,
  input logic [QUANTA_W-1:0] pause_quanta_o
);
  // R10
  det_after_eof_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pause_det_o |-> $past(rx_valid_i && rx_eof_i));
  // R8
  det_needs_good_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pause_det_o |-> $past(rx_good_i));
  // R1
  det_needs_enable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pause_det_o |-> $past(full_duplex_i && flow_ctrl_en_i));
  // R10
  det_one_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pause_det_o |=> !pause_det_o);
  // R7
  quanta_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pause_det_o |-> $stable(pause_quanta_o));
  // R12
  reset_state_chk: assert property (@(posedge clk_i)
    !rst_ni |-> (!pause_det_o && pause_quanta_o == '0));
endmodule

bind pause_detector pause_detector_chk u_pd_chk (.*);

// File: tb/pause_detector_bench.sv
module pause_detector_bench;
  localparam logic [47:0] STA = 48'h02_11_22_33_44_55;

  typedef struct packed {
    logic [1:0]  dsel;  // 0 reserved mcast, 1 station, 2 foreign
    logic [15:0] typ;
    logic [15:0] opc;
    logic [15:0] qnt;
    logic [6:0]  len;
    logic        good;
    logic        fd;
    logic        fc;
    logic        exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [0:NV-1] = '{
    '{2'd0, 16'h8808, 16'h0001, 16'h1234, 7'd64, 1'b1, 1'b1, 1'b1, 1'b1, 4'd2},  // R2
    '{2'd1, 16'h8808, 16'h0001, 16'hABCD, 7'd60, 1'b1, 1'b1, 1'b1, 1'b1, 4'd3},  // R3, R4
    '{2'd2, 16'h8808, 16'h0001, 16'h1111, 7'd60, 1'b1, 1'b1, 1'b1, 1'b0, 4'd3},  // R3 foreign DA
    '{2'd0, 16'h8809, 16'h0001, 16'h2222, 7'd60, 1'b1, 1'b1, 1'b1, 1'b0, 4'd5},  // R5
    '{2'd0, 16'h0808, 16'h0001, 16'h2223, 7'd60, 1'b1, 1'b1, 1'b1, 1'b0, 4'd5},  // R5
    '{2'd0, 16'h8808, 16'h0002, 16'h3333, 7'd60, 1'b1, 1'b1, 1'b1, 1'b0, 4'd6},  // R6
    '{2'd0, 16'h8808, 16'h0001, 16'h4444, 7'd60, 1'b0, 1'b1, 1'b1, 1'b0, 4'd8},  // R8
    '{2'd0, 16'h8808, 16'h0001, 16'h5555, 7'd60, 1'b1, 1'b0, 1'b1, 1'b0, 4'd1},  // R1
    '{2'd1, 16'h8808, 16'h0001, 16'h6666, 7'd60, 1'b1, 1'b1, 1'b0, 1'b0, 4'd1},  // R1
    '{2'd0, 16'h8808, 16'h0001, 16'hFFFF, 7'd18, 1'b1, 1'b1, 1'b1, 1'b1, 4'd9},  // R9, R7
    '{2'd1, 16'h8808, 16'h0001, 16'h0000, 7'd18, 1'b1, 1'b1, 1'b1, 1'b1, 4'd7}   // R7
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        vld = 1'b0, sof = 1'b0, eof = 1'b0, good = 1'b0;
  logic [7:0]  dat = '0;
  logic        fd = 1'b1, fc = 1'b1;
  logic        det;
  logic [15:0] qnt;

  int checks = 0, fails = 0;
  logic [15:0] last_q = '0;
  logic [7:0]  fb [0:63];
  bit          finished = 1'b0;

  always #10 clk = ~clk;

  pause_detector u_pause_detector (
    .clk_i(clk), .rst_ni(rst_n), .rx_valid_i(vld), .rx_data_i(dat),
    .rx_sof_i(sof), .rx_eof_i(eof), .rx_good_i(good), .station_addr_i(STA),
    .full_duplex_i(fd), .flow_ctrl_en_i(fc),
    .pause_det_o(det), .pause_quanta_o(qnt)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic build(input logic [1:0] dsel, input logic [15:0] typ, input logic [15:0] opc,
                       input logic [15:0] q, input int seed);
    logic [47:0] da;
    da = (dsel == 2'd0) ? 48'h0180_C200_0001 : (dsel == 2'd1) ? STA : 48'h0180_C200_0002;
    for (int i = 0; i < 6; i++) fb[i] = da[(5-i)*8 +: 8];
    for (int i = 6; i < 12; i++) fb[i] = 8'(seed * 37 + i * 11); // R4 arbitrary source
    fb[12] = typ[15:8]; fb[13] = typ[7:0];
    fb[14] = opc[15:8]; fb[15] = opc[7:0];
    fb[16] = q[15:8];   fb[17] = q[7:0];
    for (int i = 18; i < 64; i++) fb[i] = 8'(i ^ seed);
  endtask

  task automatic put(input logic [7:0] d, input bit s, input bit e, input bit g);
    @(negedge clk);
    vld = 1'b1; dat = d; sof = s; eof = e; good = g;
  endtask

  task automatic idle();
    @(negedge clk);
    vld = 1'b0; sof = 1'b0; eof = 1'b0; good = 1'b0;
  endtask

  // drive len bytes of fb with optional idle gaps; checks pulse low during frame (R10)
  task automatic send(input int len, input bit g, input int gap);
    for (int i = 0; i < len; i++) begin
      put(fb[i], i == 0, i == len - 1, g && (i == len - 1));
      if (i > 0 && det) check(1'b0, "R10 early pulse", det, 0);
      if (gap > 0 && i != len - 1) begin
        for (int k = 0; k < gap; k++) idle();
      end
    end
  endtask

  // sample cycle after eof, then cycle after that
  task automatic expect_result(input bit exp, input string req);
    idle();
    check(det === exp, req, det, exp);
    if (exp) last_q = {fb[16], fb[17]};
    check(qnt === last_q, {req, " quanta"}, qnt, last_q);
    idle();
    check(det === 1'b0, "R10 pulse width", det, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(det === 1'b0 && qnt === 16'h0, "R12 reset", {15'h0, det, qnt}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(det === 1'b0 && qnt === 16'h0, "R12 after reset", {15'h0, det, qnt}, 0);

    for (int v = 0; v < NV; v++) begin
      fd = VECS[v].fd; fc = VECS[v].fc;
      build(VECS[v].dsel, VECS[v].typ, VECS[v].opc, VECS[v].qnt, v);
      send(int'(VECS[v].len), VECS[v].good, 0);
      expect_result(VECS[v].exp, $sformatf("R%0d vec%0d", VECS[v].req, v));
    end
    fd = 1'b1; fc = 1'b1;

    // R9: truncated before last quanta byte
    build(2'd0, 16'h8808, 16'h0001, 16'h7777, 20);
    send(17, 1'b1, 0);
    expect_result(1'b0, "R9 truncated");

    // R11: restart mid-frame on a new start-of-frame
    build(2'd2, 16'h8808, 16'h0001, 16'h0BAD, 21);
    for (int i = 0; i < 9; i++) put(fb[i], i == 0, 1'b0, 1'b0);
    build(2'd1, 16'h8808, 16'h0001, 16'h0A0B, 22);
    send(40, 1'b1, 0);
    expect_result(1'b1, "R11 restart");

    // R11: idle cycles inside the frame are not counted
    build(2'd0, 16'h8808, 16'h0001, 16'hC0DE, 23);
    send(24, 1'b1, 2);
    expect_result(1'b1, "R11 gaps");

    // R11: bytes outside a frame, even a pause-like eof byte, are ignored
    build(2'd0, 16'h8808, 16'h0001, 16'h9999, 24);
    for (int i = 0; i < 18; i++) put(fb[i], 1'b0, i == 17, i == 17);
    expect_result(1'b0, "R11 stray bytes");

    // R3: station address mismatch in last address byte
    build(2'd1, 16'h8808, 16'h0001, 16'h5A5A, 25);
    fb[5] = 8'h56;
    send(30, 1'b1, 0);
    expect_result(1'b0, "R3 station last byte");

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule